// File: doc/BRIEF.md
# Quasi-Resonant Switching Cycle Sequencer

This block produces the on/off command for the power switch of a flyback converter that runs at the edge of continuous conduction. Each cycle starts with the switch on. The switch turns off when a synchronous current-limit flag trips, or when the on-time reaches its ceiling. The flag is not looked at during a short blanking interval that follows every turn-on. While the switch is off, the block waits for a synchronous valley flag, which signals that the transformer core has reset, and starts the next cycle on it.

The off phase has several bounds. Valley flags are ignored for a blanking interval that follows each turn-off. A valley that comes before the minimum switching period has elapsed is dropped. If no valley comes within a timeout window after the blanking, or if the off-time reaches its own ceiling, the next cycle starts anyway. Every duration is a parameter counted in clock cycles. The block marks each turn-on with a one-cycle pulse and reports the reason for each turn-off on one of two pulses. Dropping the enable input stops switching at once. The first cycle after enable returns starts without delay.

The parameters are expected to satisfy PER_MIN <= LEB_CYC + 1 + min(BLANK_CYC + DMG_TO, TOFF_MAX), and LEB_CYC must be smaller than TON_MAX.

Top module: `qr_cycle_seq`

## Requirements
- R1: While rst_n is low, gate, on_pulse, off_cur and off_max are all 0.
- R2: When the block is idle and en is sampled high, gate is 1 from the next clock on. on_pulse is 1 in every cycle where gate goes from 0 to 1, and in no other cycle.
- R3: cs_trip has no effect during the first LEB_CYC cycles in which gate is high after a rise.
- R4: When cs_trip is sampled high on gate-high cycle number LEB_CYC+1 or later (counting from 1 at the rise), gate is 0 in the next cycle and off_cur is 1 in that cycle. This also holds when the sample falls on the last allowed on-cycle.
- R5: When cs_trip never qualifies, gate stays high for exactly TON_MAX cycles. off_max is 1 in the first low cycle that follows.
- R6: A valley sampled in the first BLANK_CYC cycles of an off phase has no effect.
- R7: A valley sampled after the blanking interval, once the period condition holds, makes gate 1 from the next clock, with on_pulse.
- R8: Two consecutive rises of gate are at least PER_MIN cycles apart. A valley that would break this rule is dropped and is not remembered.
- R9: With no qualifying valley, the off phase lasts exactly BLANK_CYC+DMG_TO cycles when that value is not larger than TOFF_MAX.
- R10: An off phase never lasts more than TOFF_MAX cycles, even when the demag window is longer.
- R11: When en is sampled low, gate and all pulses are 0 from the next cycle on, and the timing state is cleared. When en is sampled high again, the next rise follows one clock later.
- R12: on_pulse, off_cur and off_max are one-cycle pulses, and at most one of them is high in any cycle. off_cur and off_max appear only in the first low cycle after a fall of gate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | asynchronous reset, active low |
| en | input | 1 | run enable; low forces the switch off |
| cs_trip | input | 1 | synchronous current-limit comparator flag |
| valley | input | 1 | synchronous demagnetization / valley flag |
| gate | output | 1 | switch drive command |
| on_pulse | output | 1 | one-cycle mark at each turn-on |
| off_cur | output | 1 | turn-off caused by the current flag |
| off_max | output | 1 | turn-off caused by the on-time ceiling |

## Verification
Two conflicts are of interest: a qualified current trip on the very cycle in which the on-time ceiling is reached, and a valley that arrives in the same cycle as the forced restart or the end of the minimum period. The bench times one cs_trip pulse to land on on-cycle TON_MAX and requires off_cur rather than off_max. Random valley and trip streams of several densities, together with dense valleys that run into the period clamp, push valleys onto the window and period edges. Two instances are used: one whose demag timeout ends first and one whose off-time ceiling ends first. Both are compared every cycle against a behavioural model that tracks cycle counts as plain integers.

// File: rtl/qr_cycle_seq.sv
`timescale 1ns/1ps
module qr_cycle_seq #(
  parameter int LEB_CYC   = 4,
  parameter int TON_MAX   = 40,
  parameter int BLANK_CYC = 8,
  parameter int DMG_TO    = 12,
  parameter int TOFF_MAX  = 30,
  parameter int PER_MIN   = 24
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic cs_trip,
  input  logic valley,
  output logic gate,
  output logic on_pulse,
  output logic off_cur,
  output logic off_max
);
  localparam int OFF_LIM = (BLANK_CYC + DMG_TO < TOFF_MAX) ? BLANK_CYC + DMG_TO : TOFF_MAX;
  localparam int CNT_TOP = (TON_MAX > OFF_LIM) ? TON_MAX : OFF_LIM;
  localparam int CW      = $clog2(CNT_TOP + 1);
  localparam int PW      = $clog2(PER_MIN + 1);

  typedef enum logic [1:0] {ST_IDLE, ST_ON, ST_OFF} st_e;

  st_e           st;
  logic [CW-1:0] cnt;
  logic [PW-1:0] per;
  logic          per_ok, trip_ok, on_lim, in_win, forced, fire;
  logic [PW-1:0] per_nx;

  assign per_ok  = (per == PW'(PER_MIN - 1));
  assign per_nx  = per_ok ? per : per + PW'(1);
  assign trip_ok = cs_trip && (cnt >= CW'(LEB_CYC));
  assign on_lim  = (cnt == CW'(TON_MAX - 1));
  assign in_win  = (cnt >= CW'(BLANK_CYC));
  assign forced  = (cnt >= CW'(OFF_LIM - 1));
  assign fire    = per_ok && ((valley && in_win) || forced);
  assign gate    = (st == ST_ON);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= ST_IDLE;
      cnt      <= '0;
      per      <= '0;
      on_pulse <= 1'b0;
      off_cur  <= 1'b0;
      off_max  <= 1'b0;
    end else begin
      on_pulse <= 1'b0;
      off_cur  <= 1'b0;
      off_max  <= 1'b0;
      if (!en) begin
        st  <= ST_IDLE;
        cnt <= '0;
        per <= '0;
      end else begin
        case (st)
          ST_IDLE: begin
            st       <= ST_ON;
            cnt      <= '0;
            per      <= '0;
            on_pulse <= 1'b1;
          end
          ST_ON: begin
            per <= per_nx;
            if (trip_ok) begin
              st      <= ST_OFF;
              cnt     <= '0;
              off_cur <= 1'b1;
            end else if (on_lim) begin
              st      <= ST_OFF;
              cnt     <= '0;
              off_max <= 1'b1;
            end else begin
              cnt <= cnt + CW'(1);
            end
          end
          ST_OFF: begin
            if (fire) begin
              st       <= ST_ON;
              cnt      <= '0;
              per      <= '0;
              on_pulse <= 1'b1;
            end else begin
              per <= per_nx;
              if (cnt != CW'(CNT_TOP)) cnt <= cnt + CW'(1);
            end
          end
          default: begin
            st  <= ST_IDLE;
            cnt <= '0;
            per <= '0;
          end
        endcase
      end
    end
  end
endmodule

// File: rtl/qr_cycle_seq_chk.sv
`timescale 1ns/1ps
module qr_cycle_seq_chk #(
  parameter int LEB_CYC   = 4,
  parameter int TON_MAX   = 40,
  parameter int BLANK_CYC = 8,
  parameter int DMG_TO    = 12,
  parameter int TOFF_MAX  = 30,
  parameter int PER_MIN   = 24
) (
  input logic clk,
  input logic rst_n,
  input logic en,
  input logic cs_trip,
  input logic gate,
  input logic on_pulse,
  input logic off_cur,
  input logic off_max
);
  int   hcnt, lcnt, pcnt;
  logic gate_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hcnt   <= 0;
      lcnt   <= 0;
      pcnt   <= PER_MIN;
      gate_d <= 1'b0;
    end else begin
      gate_d <= gate;
      hcnt   <= gate ? hcnt + 1 : 0;
      lcnt   <= (!en || gate) ? 0 : lcnt + 1;
      if (!en)                 pcnt <= PER_MIN;
      else if (gate && !gate_d) pcnt <= 1;
      else if (pcnt < PER_MIN) pcnt <= pcnt + 1;
    end
  end

  assert_rise_mark_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gate) |-> on_pulse);
  assert_leb_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (gate && en && hcnt < LEB_CYC && hcnt < TON_MAX - 1) |=> gate);
  assert_trip_off_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (gate && en && cs_trip && hcnt >= LEB_CYC) |=> (!gate && off_cur && !off_max));
  assert_ton_ceiling_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (gate && en && hcnt == TON_MAX - 1 && !cs_trip) |=> (!gate && off_max));
  assert_ton_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
    gate |-> (hcnt < TON_MAX));
  assert_min_period_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (gate && !gate_d) |-> (pcnt >= PER_MIN));
  assert_toff_bound_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!gate && en) |-> (lcnt < TOFF_MAX));
  assert_disable_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (!gate && !on_pulse));
  assert_pulse_excl_R12: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({on_pulse, off_cur, off_max}));
  assert_mark_gate_R12: assert property (@(posedge clk) disable iff (!rst_n)
    on_pulse |-> gate);
  assert_off_after_fall_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (off_cur || off_max) |-> (!gate && $past(gate)));
endmodule

bind qr_cycle_seq qr_cycle_seq_chk #(
  .LEB_CYC(LEB_CYC), .TON_MAX(TON_MAX), .BLANK_CYC(BLANK_CYC),
  .DMG_TO(DMG_TO), .TOFF_MAX(TOFF_MAX), .PER_MIN(PER_MIN)
) u_chk (
  .clk(clk), .rst_n(rst_n), .en(en), .cs_trip(cs_trip), .gate(gate),
  .on_pulse(on_pulse), .off_cur(off_cur), .off_max(off_max)
);

// File: tb/qr_cycle_seq_bench.sv
`timescale 1ns/1ps
module qr_ref_model #(
  parameter int LEB_CYC   = 4,
  parameter int TON_MAX   = 40,
  parameter int BLANK_CYC = 8,
  parameter int DMG_TO    = 12,
  parameter int TOFF_MAX  = 30,
  parameter int PER_MIN   = 24
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        en,
  input  logic        cs,
  input  logic        valley,
  output logic        e_gate,
  output logic        e_on,
  output logic        e_cur,
  output logic        e_max,
  output logic [23:0] tag
);
  int ph, hi, lo, since, lim;
  logic win;

  always @(posedge clk or negedge rst_n) begin
    lim = (BLANK_CYC + DMG_TO < TOFF_MAX) ? BLANK_CYC + DMG_TO : TOFF_MAX;
    if (!rst_n) begin
      ph = 0; hi = 0; lo = 0; since = 0;
      e_on = 0; e_cur = 0; e_max = 0; tag = "R1 ";
    end else begin
      e_on = 0; e_cur = 0; e_max = 0;
      if (!en) begin
        ph = 0; tag = "R11";
      end else if (ph == 0) begin
        ph = 1; hi = 1; since = 1; e_on = 1; tag = "R2 ";
      end else if (ph == 1) begin
        since++;
        if (cs && hi > LEB_CYC) begin
          ph = 2; lo = 1; e_cur = 1; tag = "R4 ";
        end else if (hi == TON_MAX) begin
          ph = 2; lo = 1; e_max = 1; tag = "R5 ";
        end else begin
          hi++; tag = cs ? "R3 " : "R12";
        end
      end else begin
        win = (lo > BLANK_CYC);
        if (since >= PER_MIN && ((valley && win) || lo >= lim)) begin
          ph = 1; hi = 1; since = 1; e_on = 1;
          if (valley && win) tag = "R7 ";
          else tag = (BLANK_CYC + DMG_TO <= TOFF_MAX) ? "R9 " : "R10";
        end else begin
          tag = (valley && !win) ? "R6 " : (valley ? "R8 " : "R12");
          lo++; since++;
        end
      end
    end
    e_gate = (ph == 1);
  end
endmodule

module qr_cycle_seq_bench;
  logic clk = 1'b0, rst_n = 1'b0, en = 1'b0, cs_trip = 1'b0, valley = 1'b0;
  logic ga, oa, ca, ma, gb, ob, cb, mb;
  logic xga, xoa, xca, xma, xgb, xob, xcb, xmb;
  logic [23:0] ta, tb;
  int checks = 0, errors = 0, n_cur = 0, n_max = 0;

  always #2.5 clk = ~clk;

  qr_cycle_seq u_qr_cycle_seq (.clk(clk), .rst_n(rst_n), .en(en), .cs_trip(cs_trip),
    .valley(valley), .gate(ga), .on_pulse(oa), .off_cur(ca), .off_max(ma));
  qr_cycle_seq #(.DMG_TO(40)) u_qr_cycle_seq_b (.clk(clk), .rst_n(rst_n), .en(en),
    .cs_trip(cs_trip), .valley(valley), .gate(gb), .on_pulse(ob), .off_cur(cb), .off_max(mb));

  qr_ref_model m_a (.clk(clk), .rst_n(rst_n), .en(en), .cs(cs_trip), .valley(valley),
    .e_gate(xga), .e_on(xoa), .e_cur(xca), .e_max(xma), .tag(ta));
  qr_ref_model #(.DMG_TO(40)) m_b (.clk(clk), .rst_n(rst_n), .en(en), .cs(cs_trip),
    .valley(valley), .e_gate(xgb), .e_on(xob), .e_cur(xcb), .e_max(xmb), .tag(tb));

  always @(negedge clk) begin
    checks += 2;
    if ({ga, oa, ca, ma} !== {xga, xoa, xca, xma}) begin
      errors++;
      $display("FAIL %s inst A t=%0t actual gate/on/cur/max=%b expected=%b", ta, $time,
               {ga, oa, ca, ma}, {xga, xoa, xca, xma});
    end
    if ({gb, ob, cb, mb} !== {xgb, xob, xcb, xmb}) begin
      errors++;
      $display("FAIL %s inst B t=%0t actual gate/on/cur/max=%b expected=%b", tb, $time,
               {gb, ob, cb, mb}, {xgb, xob, xcb, xmb});
    end
    if (oa || ob) begin
      checks++;
      if ((oa && !ga) || (ob && !gb)) begin
        errors++;
        $display("FAIL R12 on_pulse without gate actual gate=%b/%b expected 1/1", ga, gb);
      end
    end
    if (ca) n_cur++;
    if (ma) n_max++;
  end

  task automatic run_seg(input int n, input int p_cs, input int p_v, input int p_dis);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      cs_trip = (($urandom % 100) < p_cs);
      valley  = (($urandom % 100) < p_v);
      en      = !(($urandom % 1000) < p_dis);
    end
  endtask

  initial begin
    #750000;
    errors++;
    $display("FAIL watchdog expired actual running expected finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(7));
    repeat (4) @(negedge clk);
    checks++;
    if (ga || oa || ca || ma || gb || ob || cb || mb) begin
      errors++;
      $display("FAIL R1 outputs during reset actual %b%b%b%b expected 0000", ga, oa, ca, ma);
    end
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    en = 1'b1;
    run_seg(3000, 0, 0, 0);     // R5 R9 R10
    run_seg(2000, 100, 0, 0);   // R4 after R3 blanking
    run_seg(2000, 100, 100, 0); // R8 period clamp, R6 valley in blanking
    run_seg(3000, 5, 20, 0);    // R7
    run_seg(3000, 10, 30, 5);   // R11 disable/re-enable
    run_seg(1000, 50, 50, 20);
    // Coincidence: qualified trip on the last allowed on-cycle (R4 over R5)
    @(negedge clk);
    cs_trip = 0; valley = 0; en = 0;
    @(negedge clk);
    en = 1;
    @(negedge clk);
    while (!ga) @(negedge clk);
    repeat (39) @(negedge clk);
    cs_trip = 1;
    @(negedge clk);
    cs_trip = 0;
    checks++;
    if (!(ca && !ma && !ga)) begin
      errors++;
      $display("FAIL R4 trip at on ceiling actual cur/max/gate=%b%b%b expected 100", ca, ma, ga);
    end
    repeat (50) @(negedge clk);
    checks++;
    if (n_cur == 0) begin
      errors++;
      $display("FAIL R4 no current turn-off seen actual %0d expected >0", n_cur);
    end
    checks++;
    if (n_max == 0) begin
      errors++;
      $display("FAIL R5 no ceiling turn-off seen actual %0d expected >0", n_max);
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule